// File: doc/BRIEF.md
# Three-Cell Scan Chain with Injectable Stuck-At Fault

This block is a tiny sequential circuit built from three mux-D scan cells that are chained into one serial path. In functional mode the first and third cells sample two primary inputs. The middle cell samples an internal AND gate whose operands are the first and third cells. That gate cannot be driven or watched directly from the ports. The only way to reach it is to load the chain serially, capture once, and unload the chain serially.

A two-bit fault selector can force the gate output to a constant 0 or a constant 1. Test logic can use this to check that a scan sequence really tells a good gate apart from a broken one.

A typical test runs in three phases:
1. Hold the scan enable high and clock in three bits.
2. Drop the scan enable for one clock to capture.
3. Raise it again and clock the captured bits out, comparing each one against the fault-free value.

Top module: `scan_chain3`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, all three cells hold 0, so `scan_out` reads 0.
- R2: With `scan_en` = 1, each rising clock edge moves the chain one place. Cell 1 takes `scan_in`, cell 2 takes cell 1, and cell 3 takes cell 2.
- R3: `scan_out` always shows cell 3. After a shift edge it equals the value cell 2 held before that edge.
- R4: With `scan_en` = 0, a rising edge loads cell 1 from `func_a` and cell 3 from `func_c`.
- R5: With `scan_en` = 0 and `fault_sel` equal to 2'b00 or 2'b11 (no fault), a rising edge loads cell 2 with the AND of cell 1 and cell 3 as they stood before the edge.
- R6: With `scan_en` = 0 and `fault_sel` = 2'b01 (stuck-at-0), a rising edge loads cell 2 with 0.
- R7: With `scan_en` = 0 and `fault_sel` = 2'b10 (stuck-at-1), a rising edge loads cell 2 with 1.
- R8: While `scan_en` = 1, `fault_sel`, `func_a` and `func_c` have no effect on the data shifted along the chain or seen at `scan_out`.
- R9: Shifting the serial bits 1, 0, 1 (in that order) leaves cell 1 = 1, cell 2 = 0 and cell 3 = 1. Both gate operands are then high, so one capture edge without a fault sets cell 2 to 1, and with stuck-at-0 sets it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all cells |
| rst_n | input | 1 | Active-low asynchronous reset, clears every cell |
| scan_en | input | 1 | 1 selects serial shift, 0 selects functional capture |
| scan_in | input | 1 | Serial input feeding cell 1 during shift |
| func_a | input | 1 | Functional input of cell 1 |
| func_c | input | 1 | Functional input of cell 3 |
| fault_sel | input | 2 | Gate fault control: 00/11 none, 01 stuck-at-0, 10 stuck-at-1 |
| scan_out | output | 1 | Serial output, taken from cell 3 |

## Verification
The bench sweeps all eight three-bit serial loads, against all four fault codes and all four combinations of the two functional inputs. Each combination is followed by one capture and a full unload.

The unloaded bit from cell 2 separates a healthy gate from either stuck value. Stuck-at-0 only shows up when both operands are 1, and stuck-at-1 shows up whenever at least one operand is 0.

The unloaded bits from cells 1 and 3 confirm the functional inputs were captured into the right cells. During shifts the fault code and functional inputs are changed on purpose, so any leak of them into the serial path shows up at the output. The 1, 0, 1 load is run on its own as a directed case, covering both the plain unload and the capture.

// File: rtl/scan_chain3_pkg.sv
`timescale 1ns/1ps
package scan_chain3_pkg;

    // Number of scan cells in the chain.
    localparam int NUM_CELLS = 3;

    // Which cells feed the gate, and which cell captures its output.
    localparam int GATE_OP_LO = 0;
    localparam int GATE_OP_HI = NUM_CELLS - 1;
    localparam int GATE_SINK  = 1;

    localparam int FSEL_W = 2;

    typedef enum logic [FSEL_W-1:0] {
        FLT_NONE     = 2'b00,
        FLT_STUCK0   = 2'b01,
        FLT_STUCK1   = 2'b10,
        FLT_NONE_ALT = 2'b11
    } fault_mode_e;

endpackage

// File: rtl/scan_chain3_cell.sv
`timescale 1ns/1ps
module scan_chain3_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_scan,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);

    logic d_next;

    always_comb begin
        d_next = sel_scan ? d_scan : d_func;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d_next;
        end
    end

endmodule

// File: rtl/scan_chain3_fault_gate.sv
`timescale 1ns/1ps
module scan_chain3_fault_gate
    import scan_chain3_pkg::*;
(
    input  logic              op_a,
    input  logic              op_b,
    input  logic [FSEL_W-1:0] fault_sel,
    output logic              y
);

    fault_mode_e mode;
    logic        good;

    always_comb begin
        mode = fault_mode_e'(fault_sel);
        good = op_a & op_b;
        unique case (mode)
            FLT_STUCK0:   y = 1'b0;
            FLT_STUCK1:   y = 1'b1;
            FLT_NONE,
            FLT_NONE_ALT: y = good;
            default:      y = good;
        endcase
    end

endmodule

// File: rtl/scan_chain3.sv
`timescale 1ns/1ps
module scan_chain3
    import scan_chain3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic              func_a,
    input  logic              func_c,
    input  logic [FSEL_W-1:0] fault_sel,
    output logic              scan_out
);

    logic [NUM_CELLS-1:0] cell_q;
    logic [NUM_CELLS-1:0] func_d;
    logic                 gate_y;

    scan_chain3_fault_gate u_gate (
        .op_a      (cell_q[GATE_OP_LO]),
        .op_b      (cell_q[GATE_OP_HI]),
        .fault_sel (fault_sel),
        .y         (gate_y)
    );

    // Route each cell's functional input.
    always_comb begin
        func_d             = '0;
        func_d[GATE_OP_LO] = func_a;
        func_d[GATE_SINK]  = gate_y;
        func_d[GATE_OP_HI] = func_c;
    end

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        logic ser_d;

        if (i == 0) begin : g_head
            assign ser_d = scan_in;
        end else begin : g_link
            assign ser_d = cell_q[i-1];
        end

        scan_chain3_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_scan (scan_en),
            .d_func   (func_d[i]),
            .d_scan   (ser_d),
            .q        (cell_q[i])
        );
    end

    assign scan_out = cell_q[NUM_CELLS-1];

endmodule

// File: rtl/scan_chain3_chk.sv
`timescale 1ns/1ps
module scan_chain3_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scan_en,
    input logic         scan_in,
    input logic         func_a,
    input logic         func_c,
    input logic [1:0]   fault_sel,
    input logic [N-1:0] cells,
    input logic         scan_out
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (cells == '0 && scan_out == 1'b0));

    p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (cells[0] == $past(scan_in)
                     && cells[1] == $past(cells[0])
                     && cells[2] == $past(cells[1])));

    p_out_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (scan_out == $past(cells[1])));

    p_capture_func_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (cells[0] == $past(func_a) && cells[2] == $past(func_c)));

    p_capture_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && (fault_sel == 2'b00 || fault_sel == 2'b11))
        |=> (cells[1] == $past(cells[0] & cells[2])));

    p_capture_sa0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && fault_sel == 2'b01) |=> (cells[1] == 1'b0));

    p_capture_sa1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && fault_sel == 2'b10) |=> (cells[1] == 1'b1));

endmodule

bind scan_chain3 scan_chain3_chk #(.N(scan_chain3_pkg::NUM_CELLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .func_a    (func_a),
    .func_c    (func_c),
    .fault_sel (fault_sel),
    .cells     (cell_q),
    .scan_out  (scan_out)
);

// File: tb/test_scan_chain3.sv
`timescale 1ns/1ps
module test_scan_chain3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic       func_a = 1'b0;
    logic       func_c = 1'b0;
    logic [1:0] fault_sel = 2'b00;
    logic       scan_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    scan_chain3 i_scan_chain3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .scan_in   (scan_in),
        .func_a    (func_a),
        .func_c    (func_c),
        .fault_sel (fault_sel),
        .scan_out  (scan_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: scan_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one clock with the given controls; return 1 ns after the edge.
    task automatic step(input logic se, input logic si);
        @(negedge clk);
        scan_en = se;
        scan_in = si;
        @(posedge clk);
        #1;
    endtask

    function automatic logic gate_model(input logic a, input logic b, input logic [1:0] fs);
        case (fs)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            default: return a & b;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        // R1: scan_out stays low during reset.
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset output", scan_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: unload after reset yields zeros.
        for (int k = 0; k < 3; k++) begin
            check("R1 cleared cell", scan_out, 1'b0);
            step(1'b1, 1'b0);
        end

        // R9: directed 1,0,1 load.
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R9 cell3", scan_out, 1'b1);
        step(1'b1, 1'b0);
        check("R9 cell2", scan_out, 1'b0);
        step(1'b1, 1'b0);
        check("R9 cell1", scan_out, 1'b1);

        // R9: capture after 1,0,1, both with and without a stuck-at-0.
        for (int f = 0; f < 2; f++) begin
            fault_sel = (f == 0) ? 2'b00 : 2'b01;
            step(1'b1, 1'b1);
            step(1'b1, 1'b0);
            step(1'b1, 1'b1);
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
            check("R9 capture", scan_out, (f == 0) ? 1'b1 : 1'b0);
        end

        // Sweep: pattern x fault code x functional inputs.
        for (int pat = 0; pat < 8; pat++) begin
            for (int fs = 0; fs < 4; fs++) begin
                for (int fv = 0; fv < 4; fv++) begin
                    logic b1, b2, b3, fa, fc, gexp;
                    b1 = pat[2];
                    b2 = pat[1];
                    b3 = pat[0];
                    fa = fv[1];
                    fc = fv[0];

                    // R8: scramble the ignored inputs while shifting.
                    fault_sel = 2'(fs ^ 3);
                    func_a = ~fa;
                    func_c = ~fc;
                    step(1'b1, b1);
                    step(1'b1, b2);
                    step(1'b1, b3);
                    check("R2/R3/R8 shift", scan_out, b1);

                    fault_sel = 2'(fs);
                    func_a = fa;
                    func_c = fc;
                    gexp = gate_model(b3, b1, 2'(fs));
                    step(1'b0, 1'b0);
                    check("R4 cell3 capture", scan_out, fc);

                    fault_sel = 2'(fs ^ 3);
                    func_a = ~fa;
                    func_c = ~fc;
                    step(1'b1, 1'b0);
                    if (fs == 1)      check("R6 stuck0", scan_out, gexp);
                    else if (fs == 2) check("R7 stuck1", scan_out, gexp);
                    else              check("R5 good gate", scan_out, gexp);
                    step(1'b1, 1'b0);
                    check("R4 cell1 capture", scan_out, fa);
                end
            end
        end

        finish_run();
    end

endmodule